// File: doc/BRIEF.md
# Multi-Mode 16-bit Timer Counter

A general-purpose timer/counter built around a 16-bit up/down register. It takes a source tick (a one-cycle enable in the system clock domain), a gate level, a direction level and a software start. It drives one output pin, a readback of the current count and a measurement-done flag. Eight modes cover three jobs. The first is event counting. The second is measuring a gate period or a gate pulse width. The third is generating pulses, each with a programmable delay phase and a programmable width phase. Pulses can be single or repeated, and can be triggered by software or by the gate.

Each configuration input is captured only when a start is issued. That start also loads the initial count, clears the done flag and arms the selected mode. Before a start, or with a mode code of 0 or 9 to 15, the block stays silent. Two independent counters are made by placing two instances.

Top module: `gp_timer_counter`

## Requirements
- R1: While reset is held, `count_rd` reads 0 and `tc_out` and `meas_done` are low.
- R2: Until `sw_start` has been pulsed, gate, tick and config activity changes neither `count_rd` nor `tc_out`.
- R3: Mode code 1 (event count): each cycle in which `gate_in` and `src_tick` are both high moves the count by one, up when `up_dn`=1 and down when 0, wrapping modulo 2^16. The count holds while the gate is low or the tick is low, and `tc_out` stays low.
- R4: Mode code 3 (pulse width): counting begins on the first gate rise after start. The count advances once per tick while the gate is high, and that includes the rising cycle. The gate fall freezes the count and sets `meas_done`. Later gate activity is ignored until the next start.
- R5: Mode code 2 (period): counting begins on the first gate rise, so the count equals the number of ticks from one gate rise up to the next. That second rise freezes the count and sets `meas_done`.
- R6: In modes 2 and 3 the count saturates at 0xFFFF instead of wrapping.
- R7: Mode code 4 (single gated pulse): the first gate rise after start counts as the trigger. The output goes high `cfg_delay` ticks after that edge and stays high for `cfg_width` ticks. Any later gate rise produces no pulse.
- R8: Mode code 5 (single software pulse): the tick after start triggers, with no gate needed. The output goes high `cfg_delay`+1 cycles after the start edge and stays high for `cfg_width` ticks, once.
- R9: Mode code 6 (retriggered pulse): each gate rise that arrives while no pulse is in progress starts a new delay-plus-width pulse. A rise that arrives during a pulse is ignored.
- R10: Mode code 7 (continuous): triggered as in R8. Pulses of `cfg_width` high ticks repeat, separated by `cfg_delay` low ticks, until the next start.
- R11: Mode code 8 (gated continuous): runs as in R10, but the delay and width phases advance only while the registered gate is high. The output is forced low while that gate is low.
- R12: A delay or width setting of 0 behaves as 1 tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_tick | input | 1 | Count enable, one pulse per source-clock tick |
| gate_in | input | 1 | Gate level (synchronous) |
| up_dn | input | 1 | Direction in mode 1: 1 up, 0 down |
| sw_start | input | 1 | Software start: captures config and arms the mode |
| cfg_mode | input | 4 | Mode code 1..8; other values idle |
| cfg_init | input | 16 | Initial count loaded at start |
| cfg_delay | input | 16 | Delay phase length in ticks |
| cfg_width | input | 16 | High phase length in ticks |
| count_rd | output | 16 | Current count (pulse modes: ticks left in current phase) |
| meas_done | output | 1 | Measurement complete (modes 2 and 3) |
| tc_out | output | 1 | Timer output pin |

## Verification
Two events can land in the same cycle. In the measurement modes, the gate edge that starts counting coincides with a tick. In the retriggered mode, a gate rise can arrive while the width phase of an earlier pulse is still running. The bench raises the gate on a cycle where the tick is active and checks that the count includes that tick. It also toggles the gate in the middle of a mode-6 pulse and counts output rising edges, which must show exactly one pulse per accepted trigger. A saturation run starting at 0xFFFD checks that the count stops at 0xFFFF when the gate pulse is longer than the remaining range.

// File: rtl/tc_pkg.sv
package tc_pkg;
   localparam logic [3:0] MD_EVT    = 4'd1;
   localparam logic [3:0] MD_PER    = 4'd2;
   localparam logic [3:0] MD_PWID   = 4'd3;
   localparam logic [3:0] MD_GPULSE = 4'd4;
   localparam logic [3:0] MD_SPULSE = 4'd5;
   localparam logic [3:0] MD_RPULSE = 4'd6;
   localparam logic [3:0] MD_SCONT  = 4'd7;
   localparam logic [3:0] MD_GCONT  = 4'd8;

   typedef enum logic [1:0] {MS_WAIT, MS_RUN, MS_DONE} meas_st_e;
   typedef enum logic [1:0] {PS_IDLE, PS_DLY, PS_WID} pulse_st_e;
endpackage

// File: rtl/tc_edge.sv
module tc_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic lvl_q,
   output logic rise,
   output logic fall
);
   always_ff @(posedge clk) begin
      if (!rst_n) lvl_q <= 1'b0;
      else        lvl_q <= lvl;
   end
   assign rise = lvl & ~lvl_q;
   assign fall = ~lvl & lvl_q;
endmodule

// File: rtl/tc_count.sv
module tc_count #(
   parameter int W       = 16,
   parameter bit SAT_OPT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] init,
   input  logic         step,
   input  logic         up,
   input  logic         sat,
   output logic [W-1:0] cnt
);
   localparam logic [W-1:0] TOP = {W{1'b1}};
   logic at_top;

   generate
      if (SAT_OPT) begin : g_sat
         assign at_top = sat & up & (cnt == TOP);
      end else begin : g_wrap
         assign at_top = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt <= '0;
      else if (load)           cnt <= init;
      else if (step && !at_top) cnt <= up ? cnt + 1'b1 : cnt - 1'b1;
   end
endmodule

// File: rtl/tc_pulse.sv
module tc_pulse
   import tc_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         arm,
   input  logic         trig,
   input  logic         tick,
   input  logic         hold,
   input  logic         cont,
   input  logic [W-1:0] dly,
   input  logic [W-1:0] wid,
   output logic         pulse,
   output logic [W-1:0] rem
);
   localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};
   pulse_st_e    st;
   logic [W-1:0] dly_eff, wid_eff;
   logic         adv;

   assign dly_eff = (dly == '0) ? ONE : dly;
   assign wid_eff = (wid == '0) ? ONE : wid;
   assign adv     = tick & ~hold;

   always_ff @(posedge clk) begin
      if (!rst_n || arm) begin
         st  <= PS_IDLE;
         rem <= '0;
      end else begin
         case (st)
            PS_IDLE: if (trig) begin
               st  <= PS_DLY;
               rem <= dly_eff;
            end
            PS_DLY: if (adv) begin
               if (rem == ONE) begin
                  st  <= PS_WID;
                  rem <= wid_eff;
               end else rem <= rem - 1'b1;
            end
            PS_WID: if (adv) begin
               if (rem == ONE) begin
                  st  <= cont ? PS_DLY : PS_IDLE;
                  rem <= cont ? dly_eff : '0;
               end else rem <= rem - 1'b1;
            end
            default: st <= PS_IDLE;
         endcase
      end
   end

   assign pulse = (st == PS_WID);
endmodule

// File: rtl/gp_timer_counter.sv
module gp_timer_counter
   import tc_pkg::*;
#(
   parameter int W             = 16,
   parameter bit MEAS_SATURATE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         src_tick,
   input  logic         gate_in,
   input  logic         up_dn,
   input  logic         sw_start,
   input  logic [3:0]   cfg_mode,
   input  logic [W-1:0] cfg_init,
   input  logic [W-1:0] cfg_delay,
   input  logic [W-1:0] cfg_width,
   output logic [W-1:0] count_rd,
   output logic         meas_done,
   output logic         tc_out
);
   generate
      if (W < 4) begin : g_bad_width
         $error("gp_timer_counter: W must be at least 4");
      end
   endgenerate

   logic [3:0]   mode_q;
   logic [W-1:0] dly_q, wid_q, cnt, rem;
   logic         running, fired, done_q;
   meas_st_e     mst;
   logic         gate_q, rise, fall;
   logic         is_meas, is_pulse, end_evt, step, trig, hold, pulse;

   tc_edge u_edge (
      .clk(clk), .rst_n(rst_n), .lvl(gate_in),
      .lvl_q(gate_q), .rise(rise), .fall(fall)
   );

   assign is_meas  = (mode_q == MD_PER) || (mode_q == MD_PWID);
   assign is_pulse = (mode_q >= MD_GPULSE) && (mode_q <= MD_GCONT);
   assign end_evt  = (mode_q == MD_PER) ? rise : fall;

   always_comb begin
      step = 1'b0;
      if (running && src_tick) begin
         if (mode_q == MD_EVT) step = gate_in;
         else if (is_meas)
            step = ((mst == MS_WAIT) && rise) || ((mst == MS_RUN) && !end_evt);
      end
   end

   always_comb begin
      trig = 1'b0;
      if (running) begin
         case (mode_q)
            MD_GPULSE: trig = rise & ~fired;
            MD_RPULSE: trig = rise;
            MD_SPULSE, MD_SCONT, MD_GCONT: trig = ~fired;
            default:   trig = 1'b0;
         endcase
      end
   end

   assign hold = (mode_q == MD_GCONT) && !gate_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q  <= '0;
         dly_q   <= '0;
         wid_q   <= '0;
         running <= 1'b0;
         fired   <= 1'b0;
         mst     <= MS_WAIT;
         done_q  <= 1'b0;
      end else if (sw_start) begin
         mode_q  <= cfg_mode;
         dly_q   <= cfg_delay;
         wid_q   <= cfg_width;
         running <= 1'b1;
         fired   <= 1'b0;
         mst     <= MS_WAIT;
         done_q  <= 1'b0;
      end else begin
         if (trig) fired <= 1'b1;
         if (running && is_meas) begin
            case (mst)
               MS_WAIT: if (rise) mst <= MS_RUN;
               MS_RUN:  if (end_evt) begin
                  mst    <= MS_DONE;
                  done_q <= 1'b1;
               end
               default: ;
            endcase
         end
      end
   end

   tc_count #(.W(W), .SAT_OPT(MEAS_SATURATE)) u_count (
      .clk(clk), .rst_n(rst_n), .load(sw_start), .init(cfg_init),
      .step(step), .up(is_meas | up_dn), .sat(is_meas), .cnt(cnt)
   );

   tc_pulse #(.W(W)) u_pulse (
      .clk(clk), .rst_n(rst_n), .arm(sw_start), .trig(trig),
      .tick(src_tick), .hold(hold), .cont((mode_q == MD_SCONT) || (mode_q == MD_GCONT)),
      .dly(dly_q), .wid(wid_q), .pulse(pulse), .rem(rem)
   );

   assign count_rd  = is_pulse ? rem : cnt;
   assign meas_done = done_q;
   assign tc_out    = pulse & ~hold;
endmodule

// File: rtl/tc_checker.sv
module tc_checker #(
   parameter int W = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic         sw_start,
   input logic         gate_in,
   input logic         running,
   input logic [3:0]   mode_q,
   input logic [W-1:0] count_rd,
   input logic         meas_done,
   input logic         tc_out
);
   localparam logic [W-1:0] TOP = {W{1'b1}};

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> (!tc_out && !meas_done)) else $error("idle output"); // R2

   AST_EVT_GATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (running && mode_q == 4'd1 && !gate_in && !sw_start) |=> $stable(count_rd))
      else $error("count moved with gate low"); // R3

   AST_NO_OUT_COUNTING: assert property (@(posedge clk) disable iff (!rst_n)
      (running && mode_q >= 4'd1 && mode_q <= 4'd3) |-> !tc_out)
      else $error("output in count mode"); // R3

   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (meas_done && !sw_start) |=> meas_done) else $error("done dropped"); // R4

   AST_DONE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      meas_done |-> (mode_q == 4'd2 || mode_q == 4'd3)) else $error("done in wrong mode"); // R5

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (running && (mode_q == 4'd2 || mode_q == 4'd3) && count_rd == TOP && !sw_start)
      |=> count_rd == TOP) else $error("measurement wrapped"); // R6
endmodule

bind gp_timer_counter tc_checker #(.W(W)) u_chk (
   .clk(clk), .rst_n(rst_n), .sw_start(sw_start), .gate_in(gate_in),
   .running(running), .mode_q(mode_q), .count_rd(count_rd),
   .meas_done(meas_done), .tc_out(tc_out)
);

// File: tb/gp_timer_counter_tb.sv
`timescale 1ns/1ps
module gp_timer_counter_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        src_tick = 1'b1;
   logic        gate_in = 1'b0;
   logic        up_dn = 1'b1;
   logic        sw_start = 1'b0;
   logic [3:0]  cfg_mode = 4'd0;
   logic [15:0] cfg_init = 16'd0;
   logic [15:0] cfg_delay = 16'd0;
   logic [15:0] cfg_width = 16'd0;
   logic [15:0] count_rd;
   logic        meas_done;
   logic        tc_out;

   int total = 0;
   int bad = 0;
   bit fin = 1'b0;

   always #4 clk = ~clk;

   gp_timer_counter u_dut (
      .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .gate_in(gate_in),
      .up_dn(up_dn), .sw_start(sw_start), .cfg_mode(cfg_mode),
      .cfg_init(cfg_init), .cfg_delay(cfg_delay), .cfg_width(cfg_width),
      .count_rd(count_rd), .meas_done(meas_done), .tc_out(tc_out)
   );

   // {mode, delay, width, first high sample, high sample count}
   localparam logic [35:0] VEC [8] = '{
      {4'd5, 8'd3, 8'd2, 8'd4, 8'd2},
      {4'd5, 8'd0, 8'd0, 8'd2, 8'd1},
      {4'd5, 8'd1, 8'd5, 8'd2, 8'd5},
      {4'd5, 8'd7, 8'd1, 8'd8, 8'd1},
      {4'd4, 8'd2, 8'd3, 8'd5, 8'd3},
      {4'd4, 8'd0, 8'd4, 8'd4, 8'd4},
      {4'd4, 8'd5, 8'd0, 8'd8, 8'd1},
      {4'd4, 8'd1, 8'd1, 8'd4, 8'd1}
   };

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic start_cfg(input logic [3:0] m, input logic [15:0] ini,
                            input logic [15:0] d, input logic [15:0] w);
      @(negedge clk);
      cfg_mode = m; cfg_init = ini; cfg_delay = d; cfg_width = w;
      sw_start = 1'b1;
      @(negedge clk);
      sw_start = 1'b0;
   endtask

   initial begin
      int first, hi, hi2, edges;
      logic prev;
      // R1 reset state
      step(3);
      chk("R1 count", count_rd, 0);
      chk("R1 out", tc_out, 0);
      chk("R1 done", meas_done, 0);
      rst_n = 1'b1;

      // R2 no start: activity has no effect
      cfg_mode = 4'd5; cfg_init = 16'h0033; hi = 0;
      for (int k = 0; k < 12; k++) begin
         gate_in = k[1];
         if (tc_out) hi++;
         @(negedge clk);
      end
      gate_in = 1'b0;
      chk("R2 out", hi, 0);
      chk("R2 count", count_rd, 0);

      // R7/R8/R12 table walk
      for (int i = 0; i < 8; i++) begin
         gate_in = 1'b0;
         start_cfg(VEC[i][35:32], 16'd0, {8'd0, VEC[i][31:24]}, {8'd0, VEC[i][23:16]});
         first = -1; hi = 0;
         for (int k = 0; k < 40; k++) begin
            if (tc_out) begin
               hi++;
               if (first < 0) first = k;
            end
            if (VEC[i][35:32] == 4'd4) begin
               if (k == 2)  gate_in = 1'b1;
               if (k == 20) gate_in = 1'b0;
               if (k == 22) gate_in = 1'b1;
            end
            @(negedge clk);
         end
         chk((VEC[i][35:32] == 4'd4) ? "R7 first (R12)" : "R8 first (R12)", first, int'(VEC[i][15:8]));
         chk((VEC[i][35:32] == 4'd4) ? "R7 width (R12)" : "R8 width (R12)", hi, int'(VEC[i][7:0]));
      end
      gate_in = 1'b0;

      // R3 event count up, hold, tick low, down with wrap
      up_dn = 1'b1;
      start_cfg(4'd1, 16'd10, 16'd0, 16'd0);
      chk("R3 init", count_rd, 10);
      gate_in = 1'b1; step(5); gate_in = 1'b0;
      chk("R3 up", count_rd, 15);
      step(3);
      chk("R3 gate low hold", count_rd, 15);
      src_tick = 1'b0; gate_in = 1'b1; step(3);
      chk("R3 tick low hold", count_rd, 15);
      gate_in = 1'b0; src_tick = 1'b1;
      up_dn = 1'b0;
      start_cfg(4'd1, 16'd2, 16'd0, 16'd0);
      gate_in = 1'b1; step(4); gate_in = 1'b0;
      chk("R3 down wrap", count_rd, 16'hFFFE);
      up_dn = 1'b1;

      // R4 pulse width
      start_cfg(4'd3, 16'd0, 16'd0, 16'd0);
      step(2); gate_in = 1'b1; step(6);
      chk("R4 running count", count_rd, 6);
      chk("R4 not done", meas_done, 0);
      gate_in = 1'b0; step(1);
      chk("R4 width", count_rd, 6);
      chk("R4 done", meas_done, 1);
      gate_in = 1'b1; step(3); gate_in = 1'b0; step(2);
      chk("R4 single", count_rd, 6);

      // R6 saturation
      start_cfg(4'd3, 16'hFFFD, 16'd0, 16'd0);
      step(2); gate_in = 1'b1; step(6); gate_in = 1'b0; step(1);
      chk("R6 saturate", count_rd, 16'hFFFF);
      chk("R6 done", meas_done, 1);

      // R5 period
      start_cfg(4'd2, 16'd0, 16'd0, 16'd0);
      step(2); gate_in = 1'b1; step(4); gate_in = 1'b0; step(5);
      chk("R5 not done", meas_done, 0);
      gate_in = 1'b1; step(1);
      chk("R5 period", count_rd, 9);
      chk("R5 done", meas_done, 1);
      gate_in = 1'b0;

      // R9 retrigger, with a rise during a pulse
      start_cfg(4'd6, 16'd0, 16'd1, 16'd2);
      hi = 0; edges = 0; prev = 1'b0;
      for (int k = 0; k < 30; k++) begin
         if (tc_out) hi++;
         if (tc_out && !prev) edges++;
         prev = tc_out;
         if (k == 2 || k == 4 || k == 12) gate_in = 1'b1;
         if (k == 3 || k == 8) gate_in = 1'b0;
         @(negedge clk);
      end
      chk("R9 pulses", edges, 2);
      chk("R9 high", hi, 4);
      gate_in = 1'b0;

      // R10 continuous
      start_cfg(4'd7, 16'd0, 16'd2, 16'd1);
      hi = 0;
      for (int k = 0; k < 30; k++) begin
         if (tc_out) hi++;
         @(negedge clk);
      end
      chk("R10 high", hi, 9);

      // R11 gated continuous
      start_cfg(4'd8, 16'd0, 16'd1, 16'd1);
      hi = 0; hi2 = 0;
      for (int k = 0; k < 40; k++) begin
         if (tc_out) begin
            if (k < 20) hi++;
            else hi2++;
         end
         if (k == 20) gate_in = 1'b1;
         @(negedge clk);
      end
      chk("R11 gate low", hi, 0);
      chk("R11 gate high", hi2, 9);
      gate_in = 1'b0;

      fin = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #1000000;
      if (!fin) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule